// File: doc/BRIEF.md
# Cumulative Histogram Accumulator Sequencer

This block converts a histogram stored in an on-block synchronous RAM into its cumulative distribution, in place. When the active-low start input is first seen low, an address counter and a running-sum register are cleared. The counter then walks the bins from address 0 upward. Each bin's stored count is read and added to the running sum. The new sum is written back over that bin and is driven onto the 24-bit output bus in the same cycle. When the walk ends, every bin holds the sum of itself and all lower bins, and the output keeps the grand total.

The address path is three registers deep. The write enable travels through a matching three-stage valid pipeline, so every write-back lands on the bin whose data produced it. The counter stops at the last bin, so no stray write can hit bin 0 again. Raising the start input stops write-back at once, including writes already in flight. The block then acts as a lookup table: an external address returns that bin's contents on the output three clocks later. A fill port loads the histogram before a pass.

Top module: `cdf_accum`

## Requirements
- R1: After reset and until the first clock edge that samples start_n low, dout is 0, whatever is applied on lut_addr.
- R2: On the first edge that samples start_n low, the counter and the running sum clear. dout reads 0 after that edge and after the next two edges. This applies again on every later restart.
- R3: Bins are visited in ascending address order. Bin i is written back on edge E0+4+i, where E0 is the clearing edge. The write enable is delayed three stages after address issue.
- R4: While start_n stays low, dout after edge E0+3+i equals the sum of the original contents of bins 0..i.
- R5: The running sum wraps modulo 2^24. No flag is raised on overflow.
- R6: An edge that samples start_n high performs no write-back. A bin whose write would land on or after the first such edge keeps its previous contents.
- R7: The counter stops at bin 1023 and no bin is written after bin 1023. Extra cycles with start_n low leave bin 0 unchanged.
- R8: After the last bin, dout holds the final cumulative value for as long as start_n stays low.
- R9: With start_n high, after at least one pass has begun, the contents of bin lut_addr appear on dout three edges after lut_addr is sampled.
- R10: An edge with fill_we high and no write-back stores fill_data into bin fill_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start: low clears the pass and enables write-back |
| lut_addr | input | 10 | Bin address used in lookup mode |
| fill_we | input | 1 | Histogram load strobe |
| fill_addr | input | 10 | Histogram load address |
| fill_data | input | 24 | Histogram load value |
| dout | output | 24 | Running cumulative sum, or lookup data |

## Verification
The bench targets four timing hazards. An off-by-one in the write-enable delay would put each sum in a neighbouring bin. A counter that wraps past the last bin would add the total onto bin 0 again. A write stage that ignores the start input would commit writes that were in flight when a pass was stopped. A missing clear would carry the previous total into a restarted pass. Each hazard is caught by sweeping all 1024 bins through lookup after full runs, stopped runs and restarted runs. Large bin values force the 24-bit sum to wrap and check the modulo arithmetic.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
    parameter int ADDR_W = 10;
    parameter int DATA_W = 24;
    localparam int NBINS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(NBINS - 1);

    typedef logic [ADDR_W-1:0] bin_addr_t;
    typedef logic [DATA_W-1:0] bin_data_t;

    typedef struct packed {
        logic      valid;
        bin_addr_t addr;
    } stage_t;

    function automatic bin_data_t wrap_add(bin_data_t a, bin_data_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/cdf_addr_seq.sv
module cdf_addr_seq
    import cdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_n,
    output logic      start_edge,
    output logic      active,
    output logic      primed,
    output logic      issue,
    output bin_addr_t cnt
);
    logic done;

    assign start_edge = ~start_n & ~active;
    assign issue      = active & ~start_n & ~done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
            primed <= 1'b0;
            done   <= 1'b0;
        end else begin
            active <= ~start_n;
            if (start_edge) begin
                cnt    <= '0;
                done   <= 1'b0;
                primed <= 1'b1;
            end else if (issue) begin
                if (cnt == LAST_BIN) begin
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cdf_ram.sv
module cdf_ram
    import cdf_pkg::*;
(
    input  logic      clk,
    input  logic      we,
    input  bin_addr_t waddr,
    input  bin_data_t wdata,
    input  bin_addr_t raddr,
    output bin_data_t rdata
);
    bin_data_t mem [NBINS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cdf_pipe.sv
module cdf_pipe
    import cdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_n,
    input  logic      start_edge,
    input  logic      active,
    input  logic      primed,
    input  logic      issue,
    input  bin_addr_t cnt,
    input  bin_addr_t lut_addr,
    input  bin_data_t rd_data,
    output bin_addr_t rd_addr,
    output logic      wr_en,
    output bin_addr_t wr_addr,
    output bin_data_t sum,
    output logic      s2_valid
);
    stage_t s1, s2, s3;

    assign rd_addr  = s1.addr;
    assign wr_en    = s3.valid & ~start_n;
    assign wr_addr  = s3.addr;
    assign s2_valid = s2.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= '0;
            s2  <= '0;
            s3  <= '0;
            sum <= '0;
        end else begin
            s1.valid <= issue & ~start_n;
            s1.addr  <= active ? cnt : lut_addr;
            s2.valid <= s1.valid & ~start_n & ~start_edge;
            s2.addr  <= s1.addr;
            s3.valid <= s2.valid & ~start_n & ~start_edge;
            s3.addr  <= s2.addr;
            if (start_edge) begin
                sum <= '0;
            end else if (active) begin
                if (s2.valid & ~start_n) begin
                    sum <= wrap_add(sum, rd_data);
                end
            end else if (primed) begin
                sum <= rd_data;
            end
        end
    end
endmodule

// File: rtl/cdf_accum.sv
module cdf_accum
    import cdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic [ADDR_W-1:0] lut_addr,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic [DATA_W-1:0] dout
);
    logic      start_edge, active, primed, issue, s2_valid, acc_we, ram_we;
    bin_addr_t cnt, rd_addr, acc_addr, ram_waddr;
    bin_data_t rd_data, sum, ram_wdata;

    cdf_addr_seq u_seq (
        .clk(clk), .rst(rst), .start_n(start_n),
        .start_edge(start_edge), .active(active), .primed(primed),
        .issue(issue), .cnt(cnt)
    );

    cdf_pipe u_pipe (
        .clk(clk), .rst(rst), .start_n(start_n), .start_edge(start_edge),
        .active(active), .primed(primed), .issue(issue), .cnt(cnt),
        .lut_addr(lut_addr), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(acc_we), .wr_addr(acc_addr), .sum(sum), .s2_valid(s2_valid)
    );

    assign ram_we    = acc_we | fill_we;
    assign ram_waddr = acc_we ? acc_addr : fill_addr;
    assign ram_wdata = acc_we ? sum : fill_data;

    cdf_ram u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign dout = sum;
endmodule

module cdf_accum_chk
    import cdf_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start_n,
    input logic      active,
    input logic      primed,
    input logic      issue,
    input logic      acc_we,
    input logic      s2_valid,
    input bin_addr_t cnt,
    input bin_data_t dout
);
    assert_pre_R1: assert property (@(posedge clk) disable iff (rst)
        !primed |-> dout == '0);
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(start_n) |=> (dout == '0 && cnt == '0));
    assert_we_align_R3: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> $past(issue, 3));
    assert_wr_gate_R6: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> !start_n);
    assert_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST_BIN && active && !start_n) |=> cnt == LAST_BIN);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !start_n && !s2_valid) |=> $stable(dout));
endmodule

bind cdf_accum cdf_accum_chk u_chk (
    .clk(clk), .rst(rst), .start_n(start_n), .active(active),
    .primed(primed), .issue(issue), .acc_we(acc_we),
    .s2_valid(s2_valid), .cnt(cnt), .dout(dout)
);

// File: tb/cdf_accum_test.sv
`timescale 1ns/1ps
module cdf_accum_test;
    localparam int AW = 10;
    localparam int DW = 24;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_n = 1'b1;
    logic [AW-1:0] lut_addr = '0;
    logic          fill_we = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic [DW-1:0] dout;

    logic [DW-1:0] model [NB];
    logic [DW-1:0] pref  [NB];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cdf_accum uut (
        .clk(clk), .rst(rst), .start_n(start_n), .lut_addr(lut_addr),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
        .dout(dout)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compute_prefix();
        logic [DW-1:0] s = '0;
        for (int i = 0; i < NB; i++) begin
            s = s + model[i];
            pref[i] = s;
        end
    endtask

    task automatic load(input int kind);
        for (int i = 0; i < NB; i++) begin
            fill_we   = 1'b1;
            fill_addr = AW'(i);
            if (kind == 0) fill_data = DW'((i * 37 + 5) % 251);
            else           fill_data = DW'(24'hF00000 + i * 977);
            model[i] = fill_data;
            tick();
        end
        fill_we = 1'b0;
    endtask

    // run a pass of k sampled-low edges (k large means a full pass plus hold)
    task automatic run_pass(input int k, input string req);
        compute_prefix();
        start_n = 1'b0;
        for (int e = 0; e < k; e++) begin
            tick();
            if (e == k - 1) start_n = 1'b1;
            if (e < 3) check("R2", dout, '0);
            else if (e - 3 < NB) check(req, dout, pref[e - 3]);
            else check("R8", dout, pref[NB - 1]);
        end
        for (int i = 0; i < NB; i++)
            if (i <= k - 5) model[i] = pref[i];
        tick();
        tick();
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < NB; a++) begin
            lut_addr = AW'(a);
            tick(); tick(); tick();
            check(req, dout, model[a]);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        check("R1", dout, '0);
        load(0);
        for (int a = 0; a < 8; a++) begin
            lut_addr = AW'(a * 100);
            tick(); tick(); tick();
            check("R1", dout, '0);
        end
        // full pass, then extra low cycles for saturation and hold
        run_pass(NB + 3 + 60, "R4");
        sweep("R3");
        check("R7", model[0], pref[0]);
        // R10: fill port writes a single bin
        fill_we = 1'b1; fill_addr = AW'(7); fill_data = 24'h0ABCDE;
        model[7] = 24'h0ABCDE;
        tick();
        fill_we = 1'b0;
        lut_addr = AW'(7);
        tick(); tick(); tick();
        check("R10", dout, 24'h0ABCDE);
        // stopped pass: only bins 0..35 written (R6)
        load(0);
        run_pass(40, "R4");
        sweep("R6");
        // restart over partially accumulated data (R2 on restart)
        run_pass(NB + 3 + 5, "R4");
        lut_addr = AW'(0);
        tick(); tick(); tick();
        check("R9", dout, model[0]);
        // wraparound pass
        load(1);
        run_pass(NB + 3 + 20, "R5");
        sweep("R5");
        lut_addr = AW'(NB - 1);
        tick(); tick(); tick();
        check("R7", dout, model[NB - 1]);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule